// File: doc/BRIEF.md
# Cell Transmit Port, Physical-Layer Side

This block sits on the physical-layer side of a byte-wide cell transmit link. An upstream master owns the clock. It also drives a port address, an active-low enable, a start-of-cell marker and one data byte per clock. The block recognises one configured port number. When that number is presented, the block answers the poll with a cell-available flag one clock later. When the master then pulls enable low, the block accepts the cell.

Each cell is exactly 53 bytes. Bytes are gathered into a buffer that holds a parameterised number of whole cells. A cell becomes visible downstream only when its last byte arrives. A start-of-cell marker that arrives partway through a cell throws the partial cell away and raises a one-clock error flag. Completed cells leave through a valid/ready byte stream, with a flag on the first byte of each cell.

Top module: `cell_tx_slave`

## Requirements
- R1: After reset, out_valid, poll_oe, poll_clav and cell_err are all 0.
- R2: poll_oe is 1 exactly one clock after bus_addr equalled PORT_ID at a rising edge, and 0 otherwise. While poll_oe is 0, poll_clav is driven 0.
- R3: While poll_oe is 1, poll_clav is 1 if the committed unread bytes leave room for one more 53-byte cell or a cell transfer is in progress, and 0 otherwise. It stays 1 for the whole of a transfer.
- R4: The port is selected only when bus_addr equals PORT_ID on the last edge at which bus_en_n was 1. Bytes sent while another port is selected are ignored. The address driven while bus_en_n is 0 does not matter.
- R5: A cell is the byte sampled with bus_start=1 plus the next 52 accepted bytes. Once the 53rd byte is taken, all 53 bytes appear on out_data in order, and out_sop=1 on the first of them only.
- R6: bus_start=1 on an accepted byte while a cell is partly received discards the partial bytes. cell_err is then 1 for exactly one clock, the clock after that edge, and the new byte starts a fresh cell.
- R7: Accepted bytes with bus_start=0 while no cell is in progress are ignored.
- R8: A start-of-cell that arrives when there is no room for a full cell drops that whole cell. Stored cells are not changed, and the buffer never holds more than CELLS*53 bytes.
- R9: While out_valid=1 and out_ready=0, out_valid and out_data hold on the next clock.
- R10: Clocks with bus_en_n=1 inside a cell transfer no byte, and the cell continues when enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock driven by the master |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Port number being polled or selected |
| bus_en_n | input | 1 | Active-low byte enable |
| bus_start | input | 1 | Marks the first byte of a cell |
| bus_data | input | DATA_W | Cell byte |
| poll_clav | output | 1 | Cell-available answer to a poll (0 when not addressed) |
| poll_oe | output | 1 | High when this port drives poll_clav |
| cell_err | output | 1 | One-clock pulse on a misaligned start-of-cell |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | DATA_W | Downstream byte |
| out_sop | output | 1 | First byte of a cell downstream |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The hardest state to reach is a full buffer. In that state the cell-available flag drops and a start-of-cell must be refused, and space must then come back cell by cell while the pointers wrap. The stimulus reaches it by filling both cell slots with the drain stalled and polling. It then pushes a third cell that must vanish, and releases one byte and then the rest of a cell, polling after each step. A final cell is written into the freed slot across the wrap point. A misaligned start is produced by cutting a transfer off after 20 bytes and starting a full cell in its place.

// File: rtl/tx_slave_pkg.sv
package tx_slave_pkg;
    localparam int unsigned CELL_LEN = 53;
    localparam int unsigned IDX_W    = $clog2(CELL_LEN);
    typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/tx_byte_store.sv
module tx_byte_store #(
    parameter int unsigned DEPTH  = 106,
    parameter int unsigned PTR_W  = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tx_cell_writer.sv
module tx_cell_writer
    import tx_slave_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned PORT_ID = 3,
    parameter int unsigned DEPTH   = 106,
    parameter int unsigned PTR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_en_n,
    input  logic              bus_start,
    input  logic              room,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic              commit,
    output logic              in_cell,
    output logic              in_cell_nx,
    output logic              err
);
    typedef struct packed {
        logic             sel;
        logic             busy;
        idx_t             idx;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] base;
        logic             err;
    } wr_state_t;

    wr_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic take;
    assign take = !bus_en_n && st_q.sel;

    always_comb begin
        st_d   = st_q;
        st_d.err = 1'b0;
        we     = 1'b0;
        waddr  = st_q.wptr;
        commit = 1'b0;
        if (bus_en_n) st_d.sel = (bus_addr == ADDR_W'(PORT_ID));
        if (take) begin
            if (bus_start) begin
                if (st_q.busy) st_d.err = 1'b1;
                if (room) begin
                    we        = 1'b1;
                    waddr     = st_q.base;
                    st_d.wptr = bump(st_q.base);
                    st_d.idx  = idx_t'(1);
                    st_d.busy = 1'b1;
                end else begin
                    st_d.wptr = st_q.base;
                    st_d.idx  = '0;
                    st_d.busy = 1'b0;
                end
            end else if (st_q.busy) begin
                we        = 1'b1;
                st_d.wptr = bump(st_q.wptr);
                if (st_q.idx == idx_t'(CELL_LEN - 1)) begin
                    commit    = 1'b1;
                    st_d.base = bump(st_q.wptr);
                    st_d.idx  = '0;
                    st_d.busy = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_cell    = st_q.busy;
    assign in_cell_nx = st_d.busy;
    assign err        = st_q.err;
endmodule

// File: rtl/tx_cell_reader.sv
module tx_cell_reader
    import tx_slave_pkg::*;
#(
    parameter int unsigned DEPTH = 106,
    parameter int unsigned PTR_W = 7,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             ready,
    output logic             valid,
    output logic             sop,
    output logic [PTR_W-1:0] raddr,
    output logic             room,
    output logic             room_nx,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] rptr;
        idx_t             off;
    } rd_state_t;

    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH - CELL_LEN);

    rd_state_t st_d, st_q;
    logic pop;

    assign valid = (st_q.cnt != '0);
    assign pop   = valid && ready;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + (commit ? CNT_W'(CELL_LEN) : CNT_W'(0))
                            - (pop ? CNT_W'(1) : CNT_W'(0));
        if (pop) begin
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            st_d.off  = (st_q.off == idx_t'(CELL_LEN - 1)) ? '0 : st_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sop     = (st_q.off == '0);
    assign raddr   = st_q.rptr;
    assign room    = (st_q.cnt <= FILL_MAX);
    assign room_nx = (st_d.cnt <= FILL_MAX);
    assign count   = st_q.cnt;
endmodule

// File: rtl/cell_tx_slave.sv
module cell_tx_slave
    import tx_slave_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned PORT_ID = 3,
    parameter int unsigned CELLS   = 2,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_en_n,
    input  logic              bus_start,
    input  logic [DATA_W-1:0] bus_data,
    output logic              poll_clav,
    output logic              poll_oe,
    output logic              cell_err,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    input  logic              out_ready
);
    localparam int unsigned DEPTH = CELLS * CELL_LEN;
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic oe;
        logic clav;
    } poll_t;

    poll_t poll_d, poll_q;

    logic             wr_we, wr_commit, wr_in_cell, wr_in_cell_nx;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic             rd_room, rd_room_nx;
    logic [CNT_W-1:0] rd_count;

    tx_cell_writer #(
        .ADDR_W (ADDR_W),
        .PORT_ID(PORT_ID),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_en_n  (bus_en_n),
        .bus_start (bus_start),
        .room      (rd_room),
        .we        (wr_we),
        .waddr     (wr_addr),
        .commit    (wr_commit),
        .in_cell   (wr_in_cell),
        .in_cell_nx(wr_in_cell_nx),
        .err       (cell_err)
    );

    tx_byte_store #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk  (clk),
        .we   (wr_we),
        .waddr(wr_addr),
        .wdata(bus_data),
        .raddr(rd_addr),
        .rdata(out_data)
    );

    tx_cell_reader #(
        .DEPTH(DEPTH),
        .PTR_W(PTR_W),
        .CNT_W(CNT_W)
    ) u_reader (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (wr_commit),
        .ready  (out_ready),
        .valid  (out_valid),
        .sop    (out_sop),
        .raddr  (rd_addr),
        .room   (rd_room),
        .room_nx(rd_room_nx),
        .count  (rd_count)
    );

    always_comb begin
        poll_d.oe   = (bus_addr == ADDR_W'(PORT_ID));
        poll_d.clav = wr_in_cell_nx || rd_room_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) poll_q <= '0;
        else        poll_q <= poll_d;
    end

    assign poll_oe   = poll_q.oe;
    assign poll_clav = poll_q.clav && poll_q.oe;
endmodule

// File: rtl/tx_slave_checks.sv
module tx_slave_checks #(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned PORT_ID = 3,
    parameter int unsigned DEPTH   = 106,
    parameter int unsigned CNT_W   = 7,
    parameter int unsigned DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_en_n,
    input logic              bus_start,
    input logic              poll_oe,
    input logic              poll_clav,
    input logic              cell_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              in_cell,
    input logic [CNT_W-1:0]  count
);
    p_oe_follows_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (poll_oe == ($past(bus_addr) == ADDR_W'(PORT_ID))));

    p_clav_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_oe |-> !poll_clav);

    p_clav_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cell && poll_oe) |-> poll_clav);

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cell_err |-> $past(!bus_en_n && bus_start));

    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

bind cell_tx_slave tx_slave_checks #(
    .ADDR_W (ADDR_W),
    .PORT_ID(PORT_ID),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_en_n (bus_en_n),
    .bus_start(bus_start),
    .poll_oe  (poll_oe),
    .poll_clav(poll_clav),
    .cell_err (cell_err),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .in_cell  (wr_in_cell),
    .count    (rd_count)
);

// File: tb/test_cell_tx_slave.sv
module test_cell_tx_slave;
    localparam int PORT = 3;
    localparam int LEN  = 53;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] bus_addr;
    logic       bus_en_n, bus_start, out_ready;
    logic [7:0] bus_data;
    logic       poll_clav, poll_oe, cell_err, out_valid, out_sop;
    logic [7:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    int err_seen = 0;
    logic [7:0] exp_q[$];
    bit         exp_sop[$];

    always #10 clk = ~clk;

    cell_tx_slave #(.ADDR_W(5), .PORT_ID(PORT), .CELLS(2), .DATA_W(8)) i_cell_tx_slave (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en_n(bus_en_n),
        .bus_start(bus_start), .bus_data(bus_data), .poll_clav(poll_clav),
        .poll_oe(poll_oe), .cell_err(cell_err), .out_valid(out_valid),
        .out_data(out_data), .out_sop(out_sop), .out_ready(out_ready)
    );

    always @(negedge clk) if (rst_n === 1'b1 && cell_err === 1'b1) err_seen++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 11) ^ (i << 2));
    endfunction

    task automatic poll(input logic [4:0] a, output bit oe, output bit clav);
        @(negedge clk);
        bus_en_n = 1'b1; bus_start = 1'b0; bus_addr = a;
        @(negedge clk);
        oe = poll_oe; clav = poll_clav;
    endtask

    task automatic send_cell(input logic [4:0] a, input int seed, input int n,
                             input int gap, input bit keep);
        @(negedge clk);
        bus_en_n = 1'b1; bus_start = 1'b0; bus_addr = a;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                bus_en_n = 1'b1; bus_start = 1'b0; bus_addr = a;
                @(negedge clk);
                if (a == 5'(PORT))
                    check(poll_oe && poll_clav, "R3", "clav during transfer gap",
                          int'(poll_clav), 1);
            end
            bus_en_n = 1'b0; bus_start = (i == 0); bus_data = pat(seed, i); bus_addr = ~a;
        end
        @(negedge clk);
        bus_en_n = 1'b1; bus_start = 1'b0; bus_addr = a;
        if (keep) for (int i = 0; i < n; i++) begin
            exp_q.push_back(pat(seed, i));
            exp_sop.push_back(i == 0);
        end
    endtask

    // want < 0: drain everything with a stalling ready pattern
    task automatic take(input int want);
        int got = 0;
        bit hold = 0;
        logic [7:0] hd = '0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (hold) check(out_valid && out_data == hd, "R9", "stalled byte held",
                            int'(out_data), int'(hd));
            if (want >= 0 && got == want) break;
            if (want < 0 && !out_valid && exp_q.size() == 0) break;
            out_ready = (want >= 0) ? 1'b1 : ((k % 3) != 2);
            hold = out_valid && !out_ready;
            hd = out_data;
            if (out_valid && out_ready) begin
                got++;
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected output byte", int'(out_data), -1);
                end else begin
                    logic [7:0] e = exp_q.pop_front();
                    bit s = exp_sop.pop_front();
                    check(out_data == e, "R5", "byte value", int'(out_data), int'(e));
                    check(out_sop == s, "R5", "first-byte flag", int'(out_sop), int'(s));
                end
            end
        end
        out_ready = 1'b0;
        if (want < 0) begin
            check(exp_q.size() == 0, "R5", "bytes still expected", exp_q.size(), 0);
            check(!out_valid, "R5", "output empty after drain", int'(out_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        finish_run();
    end

    initial begin
        bit oe, clav;
        rst_n = 1'b0; bus_addr = '0; bus_en_n = 1'b1; bus_start = 1'b0;
        bus_data = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        check(!poll_oe, "R1", "poll_oe after reset", int'(poll_oe), 0);
        check(!poll_clav, "R1", "poll_clav after reset", int'(poll_clav), 0);
        check(!cell_err, "R1", "cell_err after reset", int'(cell_err), 0);

        // R2/R3 exhaustive address sweep on an empty buffer
        for (int a = 0; a < 32; a++) begin
            poll(5'(a), oe, clav);
            check(oe == (a == PORT), "R2", "poll_oe for address", int'(oe), int'(a == PORT));
            check(clav == (a == PORT), "R3", "clav with empty buffer", int'(clav),
                  int'(a == PORT));
        end

        // R5 plain cell
        send_cell(5'(PORT), 1, LEN, 0, 1);
        take(-1);

        // R10 enable gaps, R4 address changes while enable low, R9 stalls
        send_cell(5'(PORT), 2, LEN, 7, 1);
        take(-1);
        send_cell(5'(PORT), 3, LEN, 3, 1);
        take(-1);

        // R4 cell to another port is ignored
        send_cell(5'd9, 4, LEN, 0, 0);
        repeat (3) @(negedge clk);
        check(!out_valid, "R4", "cell for other port ignored", int'(out_valid), 0);

        // R7 bytes without a start marker are ignored
        @(negedge clk);
        bus_en_n = 1'b1; bus_addr = 5'(PORT);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bus_en_n = 1'b0; bus_start = 1'b0; bus_data = 8'(i);
        end
        @(negedge clk);
        bus_en_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid, "R7", "stray bytes ignored", int'(out_valid), 0);
        take(-1);
        check(err_seen == 0, "R6", "no error on aligned traffic", err_seen, 0);

        // R6 misaligned start aborts the partial cell
        send_cell(5'(PORT), 50, 20, 0, 0);
        send_cell(5'(PORT), 51, LEN, 0, 1);
        check(err_seen == 1, "R6", "one error pulse", err_seen, 1);
        take(-1);

        // R3/R8 full buffer
        send_cell(5'(PORT), 60, LEN, 0, 1);
        send_cell(5'(PORT), 61, LEN, 0, 1);
        poll(5'(PORT), oe, clav);
        check(oe && !clav, "R3", "clav low when full", int'(clav), 0);
        send_cell(5'(PORT), 62, LEN, 0, 0);
        poll(5'(PORT), oe, clav);
        check(!clav, "R8", "clav low after dropped cell", int'(clav), 0);
        take(1);
        poll(5'(PORT), oe, clav);
        check(!clav, "R3", "clav low with one byte freed", int'(clav), 0);
        take(LEN - 1);
        poll(5'(PORT), oe, clav);
        check(clav, "R3", "clav high once a cell is freed", int'(clav), 1);
        send_cell(5'(PORT), 63, LEN, 10, 1);
        take(-1);
        check(err_seen == 1, "R6", "error pulse count at end", err_seen, 1);
        finish_run();
    end
endmodule